// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing packet data from memory to a byte stream. It follows a ring of four-word descriptors. Each descriptor holds a control/status word, a byte count, the word address of a buffer and a link to the next descriptor. Software prepares a descriptor and sets its ownership bit. The engine fetches the descriptor, streams the buffer one byte at a time, and writes the control word back with ownership cleared. It then moves to the next descriptor, either through the link word or to the next consecutive slot. A descriptor flagged as the end of the ring sends the engine back to the programmed base.

When the engine meets a descriptor it does not own, it suspends and makes no further memory traffic. A poll-demand write makes it fetch that same descriptor again. Clearing the run control lets the current descriptor finish and then parks the engine. Setting run again starts from the base address.

Registers are selected by a 2-bit address:
- 0: control. Bit 0 is run and bit 1 is the interrupt enable.
- 1: ring base, as a word address.
- 2: poll demand. Writing any value is a strobe, and the register reads as zero.
- 3: status. Bit 0 is transmit-done and is cleared by writing 1. Bit 1 is suspended and bit 2 is busy; both are read-only.

The memory port is word addressed. A request is held until the acknowledge cycle, and read data is valid in that cycle.

Top module: `txring_engine`

## Requirements
- R1: After reset, all registers read zero, `irq` is 0, and neither `tx_tvalid` nor `mem_req` is asserted.
- R2: The engine reads word 0 at the descriptor address. If bit 31 (ownership) is set, it reads words 1 to 3, streams the buffer, and writes word 0 back with only bit 31 cleared.
- R3: The buffer starts at the word address in word 2 and holds word1[10:0] bytes. Bytes leave lowest byte lane first (bits 7:0 first) and consecutive words are read in turn.
- R4: `tx_tlast` is high only on the final byte of a buffer whose word 0 has bit 29 set. `tx_first` follows bit 28 and `tx_nocrc` follows bit 27, both valid while the buffer's bytes are presented.
- R5: A byte count of zero streams nothing, and ownership is still written back.
- R6: With bit 20 set, the next descriptor address is word 3. Otherwise it is the current address plus 4.
- R7: With bit 21 set, the next descriptor address is the base register. This takes priority over bit 20.
- R8: A fetched word 0 with bit 31 clear puts the engine in suspend (status bit 1). It then makes no memory request until a poll-demand write, which re-fetches the same descriptor.
- R9: Clearing run stops the engine after the current descriptor completes. Setting run from the stopped state starts fetching at the base address.
- R10: A write to the base register is ignored while run is set or the engine is busy. Otherwise it takes effect and reads back.
- R11: A descriptor with bit 30 set sets the sticky done status when it is written back. Writing 1 to status bit 0 clears it, and `irq` is done AND enable.
- R12: While `tx_tvalid` is high and `tx_tready` is low, the byte, last flag and valid are held.
- R13: The memory request, address and write enable are held until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; completes the request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| tx_tdata | output | 8 | Stream byte |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tlast | output | 1 | Final byte of a frame |
| tx_first | output | 1 | Buffer starts a frame (sideband) |
| tx_nocrc | output | 1 | Suppress CRC append (sideband) |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench targets the places where the next descriptor address is chosen:
- A chained descriptor must be followed through its link word.
- A plain descriptor must be followed by the next consecutive slot.
- An end-of-ring descriptor that also carries the chain bit must return to the base address; an engine with the wrong priority would fetch the link instead.

It also covers the remaining corner cases:
- A zero-length buffer must still return ownership. A wrong design either emits stray bytes or never clears ownership, and software then stalls.
- A stop issued in mid-buffer must leave the following owned descriptor untouched.
- A restart must begin at the base address.
- A base write made while running must be dropped.
- Backpressure that cuts across word boundaries would expose byte lanes that are skipped or repeated.
- With the interrupt enable off, the done status must still be set while `irq` stays low.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int DESC_WORDS = 4;

    // control word bit positions
    localparam int B_OWN   = 31;
    localparam int B_IRQ   = 30;
    localparam int B_LAST  = 29;
    localparam int B_FIRST = 28;
    localparam int B_NOCRC = 27;
    localparam int B_EOR   = 21;
    localparam int B_CHAIN = 20;

    // register selects
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_POLL = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH,
        W_BUFRD,
        W_STREAM,
        W_WBACK,
        W_SUSP
    } walk_state_e;

    typedef struct packed {
        logic own;
        logic irq;
        logic last;
        logic first;
        logic nocrc;
        logic eor;
        logic chain;
    } desc_ctl_t;

    function automatic desc_ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        desc_ctl_t c;
        c.own   = w[B_OWN];
        c.irq   = w[B_IRQ];
        c.last  = w[B_LAST];
        c.first = w[B_FIRST];
        c.nocrc = w[B_NOCRC];
        c.eor   = w[B_EOR];
        c.chain = w[B_CHAIN];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] release_own(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[B_OWN] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txring_csr.sv
module txring_csr
    import txring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              susp,
    input  logic              done_set,
    output logic              run,
    output logic              irq_en,
    output logic [AW-1:0]     base,
    output logic              poll,
    output logic              irq
);

    logic done;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            irq_en <= 1'b0;
            base   <= '0;
            done   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) begin
                run    <= reg_wdata[0];
                irq_en <= reg_wdata[1];
            end
            if (reg_wr && reg_addr == RA_BASE && !run && !busy) begin
                base <= reg_wdata[AW-1:0];
            end
            if (done_set) begin
                done <= 1'b1;
            end else if (reg_wr && reg_addr == RA_STAT && reg_wdata[0]) begin
                done <= 1'b0;
            end
        end
    end

    assign poll = reg_wr && (reg_addr == RA_POLL);
    assign irq  = done && irq_en;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {{(WORD_W-2){1'b0}}, irq_en, run};
            RA_BASE: reg_rdata = WORD_W'(base);
            RA_POLL: reg_rdata = '0;
            RA_STAT: reg_rdata = {{(WORD_W-3){1'b0}}, busy, susp, done};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txring_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [AW-1:0]     base,
    input  logic              poll,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast,
    output logic              tx_first,
    output logic              tx_nocrc,
    output logic              busy,
    output logic              susp,
    output logic              done_set
);

    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = $clog2(DESC_WORDS);
    localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);
    localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(DESC_WORDS - 1);

    walk_state_e       state;
    logic [AW-1:0]     ptr;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] d0;
    logic [LENW-1:0]   remain;
    logic [AW-1:0]     bufptr;
    logic [AW-1:0]     link;
    logic [WORD_W-1:0] wordbuf;
    logic [LANE_W-1:0] lane;
    desc_ctl_t         ctl;
    logic [AW-1:0]     next_ptr;

    assign ctl = decode_ctl(d0);

    // end of ring beats chaining, chaining beats sequential
    always_comb begin
        if (ctl.eor)        next_ptr = base;
        else if (ctl.chain) next_ptr = link;
        else                next_ptr = ptr + AW'(DESC_WORDS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= W_IDLE;
            ptr     <= '0;
            widx    <= '0;
            d0      <= '0;
            remain  <= '0;
            bufptr  <= '0;
            link    <= '0;
            wordbuf <= '0;
            lane    <= '0;
        end else begin
            unique case (state)
                W_IDLE: begin
                    if (run) begin
                        ptr   <= base;
                        widx  <= '0;
                        state <= W_FETCH;
                    end
                end
                W_FETCH: begin
                    if (mem_ack) begin
                        unique case (widx)
                            2'd0: d0     <= mem_rdata;
                            2'd1: remain <= mem_rdata[LENW-1:0];
                            2'd2: bufptr <= mem_rdata[AW-1:0];
                            default: link <= mem_rdata[AW-1:0];
                        endcase
                        if (widx == '0 && !mem_rdata[B_OWN]) begin
                            state <= W_SUSP;
                        end else if (widx == IDX_TOP) begin
                            widx  <= '0;
                            state <= (remain == '0) ? W_WBACK : W_BUFRD;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                W_BUFRD: begin
                    if (mem_ack) begin
                        wordbuf <= mem_rdata;
                        state   <= W_STREAM;
                    end
                end
                W_STREAM: begin
                    if (tx_tready) begin
                        remain <= remain - 1'b1;
                        if (remain == LENW'(1)) begin
                            lane  <= '0;
                            state <= W_WBACK;
                        end else if (lane == LANE_TOP) begin
                            lane   <= '0;
                            bufptr <= bufptr + 1'b1;
                            state  <= W_BUFRD;
                        end else begin
                            lane <= lane + 1'b1;
                        end
                    end
                end
                W_WBACK: begin
                    if (mem_ack) begin
                        ptr  <= next_ptr;
                        widx <= '0;
                        state <= run ? W_FETCH : W_IDLE;
                    end
                end
                W_SUSP: begin
                    if (!run) begin
                        state <= W_IDLE;
                    end else if (poll) begin
                        widx  <= '0;
                        state <= W_FETCH;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == W_FETCH) || (state == W_BUFRD) || (state == W_WBACK);
    assign mem_we    = (state == W_WBACK);
    assign mem_wdata = release_own(d0);

    always_comb begin
        unique case (state)
            W_FETCH: mem_addr = ptr + AW'(widx);
            W_BUFRD: mem_addr = bufptr;
            default: mem_addr = ptr;
        endcase
    end

    assign tx_tvalid = (state == W_STREAM);
    assign tx_tdata  = wordbuf[{lane, 3'b000} +: BYTE_W];
    assign tx_tlast  = tx_tvalid && ctl.last && (remain == LENW'(1));
    assign tx_first  = tx_tvalid && ctl.first;
    assign tx_nocrc  = tx_tvalid && ctl.nocrc;

    assign busy     = (state != W_IDLE);
    assign susp     = (state == W_SUSP);
    assign done_set = (state == W_WBACK) && mem_ack && ctl.irq;

endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast,
    output logic              tx_first,
    output logic              tx_nocrc,
    output logic              irq
);

    logic          walk_busy;
    logic          walk_susp;
    logic          walk_done;
    logic          ctl_run;
    logic          ctl_irq_en;
    logic [AW-1:0] ctl_base;
    logic          ctl_poll;

    txring_csr #(.AW(AW)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (walk_busy),
        .susp      (walk_susp),
        .done_set  (walk_done),
        .run       (ctl_run),
        .irq_en    (ctl_irq_en),
        .base      (ctl_base),
        .poll      (ctl_poll),
        .irq       (irq)
    );

    txring_walker #(.AW(AW), .LENW(LENW)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl_run),
        .base      (ctl_base),
        .poll      (ctl_poll),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_tdata  (tx_tdata),
        .tx_tvalid (tx_tvalid),
        .tx_tready (tx_tready),
        .tx_tlast  (tx_tlast),
        .tx_first  (tx_first),
        .tx_nocrc  (tx_nocrc),
        .busy      (walk_busy),
        .susp      (walk_susp),
        .done_set  (walk_done)
    );

endmodule

// File: rtl/txring_checker.sv
module txring_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_tvalid,
    input logic          tx_tready,
    input logic [7:0]    tx_tdata,
    input logic          tx_tlast,
    input logic          susp
);

    a_r13_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r12_byte_held: assert property (@(posedge clk) disable iff (rst)
        (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)));

    a_r2_wb_clears_own: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    a_r8_quiet_suspend: assert property (@(posedge clk) disable iff (rst)
        susp |-> (!mem_req && !tx_tvalid));

    a_r3_no_mem_while_streaming: assert property (@(posedge clk) disable iff (rst)
        tx_tvalid |-> !mem_req);

endmodule

bind txring_engine txring_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .tx_tvalid (tx_tvalid),
    .tx_tready (tx_tready),
    .tx_tdata  (tx_tdata),
    .tx_tlast  (tx_tlast),
    .susp      (walk_susp)
);

// File: tb/sim_txring_engine.sv
`timescale 1ns/1ps
module sim_txring_engine;

    localparam int AW = 16;
    localparam real CLK_PERIOD = 8.0;

    localparam logic [31:0] F_OWN = 32'h8000_0000;
    localparam logic [31:0] F_IRQ = 32'h4000_0000;
    localparam logic [31:0] F_LST = 32'h2000_0000;
    localparam logic [31:0] F_FST = 32'h1000_0000;
    localparam logic [31:0] F_NCR = 32'h0800_0000;
    localparam logic [31:0] F_EOR = 32'h0020_0000;
    localparam logic [31:0] F_CHN = 32'h0010_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic [7:0]    tx_tdata;
    logic          tx_tvalid, tx_tlast, tx_first, tx_nocrc, irq;
    logic          tx_tready = 1'b1;

    logic [31:0]   mem [0:255];
    logic [AW-1:0] last_rd = '0;
    logic          tb_we = 1'b0;
    logic [7:0]    tb_addr = '0;
    logic [31:0]   tb_data = '0;

    logic [7:0]    cap_data  [0:63];
    logic          cap_last  [0:63];
    logic          cap_first [0:63];
    logic          cap_nocrc [0:63];
    int            cap_n = 0;
    int            tick = 0;
    logic          bp_mode = 1'b0;
    int            n_total = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txring_engine #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_tdata(tx_tdata),
        .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast),
        .tx_first(tx_first), .tx_nocrc(tx_nocrc), .irq(irq)
    );

    // memory model: one-cycle acknowledge, registered read data
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    last_rd   <= mem_addr;
                end
            end
        end
        if (tb_we) mem[tb_addr] <= tb_data;
    end

    // sink readiness pattern
    always @(posedge clk) begin
        #1;
        tick = tick + 1;
        tx_tready = bp_mode ? ((tick % 3) != 0) : 1'b1;
    end

    // byte capture, sampled between edges
    always @(negedge clk) begin
        if (!rst && tx_tvalid && tx_tready && cap_n < 64) begin
            cap_data[cap_n]  = tx_tdata;
            cap_last[cap_n]  = tx_tlast;
            cap_first[cap_n] = tx_first;
            cap_nocrc[cap_n] = tx_nocrc;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [7:0] a, input logic [31:0] w0,
                            input logic [31:0] w1, input logic [31:0] w2,
                            input logic [31:0] w3);
        poke(a, w0);
        poke(a + 8'd1, w1);
        poke(a + 8'd2, w2);
        poke(a + 8'd3, w3);
    endtask

    // wait until suspended or idle
    task automatic settle();
        logic [31:0] s;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3000; i++) begin
            reg_read(2'd3, s);
            if (s[1] || !s[2]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(2'd0, v); check("R1", "ctrl", v, 32'h0);
        reg_read(2'd1, v); check("R1", "base", v, 32'h0);
        reg_read(2'd3, v); check("R1", "status", v, 32'h0);
        check("R1", "irq/tvalid/req", {29'b0, irq, tx_tvalid, mem_req}, 32'h0);
    endtask

    task automatic t_single_chained();
        logic [31:0] v;
        int b0;
        put_desc(8'h10, F_OWN | F_IRQ | F_LST | F_FST | F_CHN, 32'd5, 32'h80, 32'h20);
        poke(8'h20, 32'h0);
        poke(8'h80, 32'h4433_2211);
        poke(8'h81, 32'h0000_0055);
        b0 = cap_n;
        reg_write(2'd1, 32'h10);
        reg_write(2'd0, 32'h3);
        settle();
        check("R2", "byte count", 32'(cap_n - b0), 32'd5);
        for (int i = 0; i < 5; i++) begin
            check("R3", "byte value", {24'b0, cap_data[b0 + i]}, 32'h11 * (i + 1));
            check("R4", "last flag", {31'b0, cap_last[b0 + i]}, {31'b0, i == 4});
            check("R4", "first flag", {31'b0, cap_first[b0 + i]}, 32'h1);
            check("R4", "nocrc flag", {31'b0, cap_nocrc[b0 + i]}, 32'h0);
        end
        check("R2", "writeback word0", mem[8'h10], F_IRQ | F_LST | F_FST | F_CHN);
        check("R6", "chained next fetch", {16'b0, last_rd}, 32'h20);
        reg_read(2'd3, v);
        check("R8", "suspended bit", {31'b0, v[1]}, 32'h1);
        check("R11", "done status", {31'b0, v[0]}, 32'h1);
        check("R11", "irq asserted", {31'b0, irq}, 32'h1);
        reg_write(2'd3, 32'h1);
        reg_read(2'd3, v);
        check("R11", "done cleared by W1C", {31'b0, v[0]}, 32'h0);
        check("R11", "irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_poll_zero_len_eor();
        int b0;
        put_desc(8'h20, F_OWN | F_EOR | F_CHN, 32'd0, 32'h80, 32'h60);
        repeat (20) @(negedge clk);
        check("R8", "no fetch while suspended", {16'b0, last_rd}, 32'h20);
        b0 = cap_n;
        reg_write(2'd2, 32'h0);
        settle();
        check("R5", "zero length streams nothing", 32'(cap_n - b0), 32'd0);
        check("R5", "ownership returned", mem[8'h20], F_EOR | F_CHN);
        check("R7", "end of ring returns to base", {16'b0, last_rd}, 32'h10);
    endtask

    task automatic t_sequential_backpressure();
        logic [31:0] v;
        int b0;
        logic [7:0] exp_b [0:8];
        exp_b = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hC1, 8'hC2, 8'hC3};
        reg_write(2'd0, 32'h2);
        settle();
        reg_read(2'd3, v);
        check("R9", "stopped from suspend", {31'b0, v[2]}, 32'h0);
        reg_write(2'd1, 32'h30);
        reg_read(2'd1, v);
        check("R10", "base accepted when stopped", v, 32'h30);
        put_desc(8'h30, F_OWN | F_NCR, 32'd6, 32'h90, 32'h99);
        put_desc(8'h34, F_OWN | F_LST | F_CHN, 32'd3, 32'h98, 32'h40);
        poke(8'h40, 32'h0);
        poke(8'h90, 32'hA4A3_A2A1);
        poke(8'h91, 32'h0000_A6A5);
        poke(8'h98, 32'h00C3_C2C1);
        b0 = cap_n;
        bp_mode = 1'b1;
        reg_write(2'd0, 32'h3);
        settle();
        bp_mode = 1'b0;
        check("R12", "byte count under backpressure", 32'(cap_n - b0), 32'd9);
        for (int i = 0; i < 9; i++) begin
            check("R3", "byte order", {24'b0, cap_data[b0 + i]}, {24'b0, exp_b[i]});
            check("R4", "nocrc sideband", {31'b0, cap_nocrc[b0 + i]}, {31'b0, i < 6});
            check("R4", "last only at end", {31'b0, cap_last[b0 + i]}, {31'b0, i == 8});
        end
        check("R6", "sequential slot written back", mem[8'h34], F_LST | F_CHN);
        check("R6", "chain after sequential", {16'b0, last_rd}, 32'h40);
        check("R11", "no irq without request bit", {31'b0, irq}, 32'h0);
        reg_write(2'd1, 32'h70);
        reg_read(2'd1, v);
        check("R10", "base write ignored while running", v, 32'h30);
    endtask

    task automatic t_stop_restart();
        logic [31:0] v;
        int b0;
        reg_write(2'd0, 32'h0);
        settle();
        reg_write(2'd1, 32'h50);
        put_desc(8'h50, F_OWN | F_IRQ | F_CHN, 32'd4, 32'hA0, 32'h54);
        put_desc(8'h54, F_OWN | F_LST | F_CHN, 32'd4, 32'hA0, 32'h58);
        poke(8'hA0, 32'h0D0C_0B0A);
        b0 = cap_n;
        bp_mode = 1'b1;
        reg_write(2'd0, 32'h1);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (cap_n > b0) break;
        end
        reg_write(2'd0, 32'h0);
        settle();
        bp_mode = 1'b0;
        check("R9", "current buffer completes", 32'(cap_n - b0), 32'd4);
        check("R9", "current ownership returned", mem[8'h50], F_IRQ | F_CHN);
        check("R9", "next descriptor untouched", mem[8'h54], F_OWN | F_LST | F_CHN);
        reg_read(2'd3, v);
        check("R9", "idle after stop", {31'b0, v[2]}, 32'h0);
        check("R11", "done set with enable off", {31'b0, v[0]}, 32'h1);
        check("R11", "irq gated by enable", {31'b0, irq}, 32'h0);
        reg_write(2'd3, 32'h1);
        reg_write(2'd0, 32'h1);
        settle();
        check("R9", "restart fetches base", {16'b0, last_rd}, 32'h50);
        reg_read(2'd3, v);
        check("R8", "restart suspends on unowned", {31'b0, v[1]}, 32'h1);
        check("R9", "no bytes on restart", 32'(cap_n - b0), 32'd4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_single_chained();
        t_poll_zero_len_eor();
        t_sequential_backpressure();
        t_stop_restart();
        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule